// File: doc/BRIEF.md
# Nonvolatile memory write/erase controller

This block sits between a CPU register bus and an on-chip nonvolatile memory array. Software loads a 16-bit table pointer and deposits bytes one at a time into an eight-entry holding buffer. Each byte lands in the entry selected by the low three pointer bits. A timed programming cycle then commits the whole buffer, or erases the addressed row, through a simple array port.

A cycle can start only after a two-byte key has been written to a storage-less key register. The control write that sets the start bit must come next and must also keep the write-enable bit set. While the cycle runs, the start bit reads 1 and software cannot clear it. A write-error flag is raised with the cycle and lowered only when the programming timer expires normally. A warm reset that cuts a cycle short therefore leaves that flag set, and only the power-on reset clears it. A sticky completion flag drives the interrupt output.

The control register selects the target space. A configuration-space bit overrides a program/data select bit, and an erase bit turns the next cycle into an erase.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: A bus write to address 4 stores the byte in holding entry ptr[2:0]. A read of address 4 returns that entry. Entry i appears on mem_data_o[8*i+7:8*i].
- R2: The key register (address 1) keeps no data and always reads 0x00.
- R3: A start is accepted only if the last two bus accesses before the control write were key writes of 0x55 and then 0xAA. Idle cycles between them are allowed. Any other access, or the wrong order, cancels the unlock.
- R4: A control write that sets the start bit (bit 1) but leaves write-enable (bit 2) clear is ignored. The start bit stays 0 and mem_req_o stays low.
- R5: Software cannot clear the start bit. It reads 1 for the whole cycle and hardware clears it at the end.
- R6: The write-error bit (control bit 3) is set when a cycle starts and cleared only when the timer expires. After a warm reset (rst_ni) during a cycle it still reads 1. Only por_ni clears it.
- R7: With the erase bit (control bit 4) set, mem_erase_o is 1 during the cycle. Otherwise the cycle is a write and mem_erase_o is 0.
- R8: mem_space_o is 2'b10 (configuration) when control bit 6 is set, whatever the value of bit 7. Otherwise it is 2'b01 (program) when bit 7 is 1 and 2'b00 (data) when bit 7 is 0.
- R9: mem_req_o stays high for exactly PROG_CYCLES clock cycles. mem_row_o equals ptr[15:3].
- R10: The completion flag (address 5, bit 0, also on irq_o) sets when a cycle ends. It ignores writes of 1 and is cleared by writing 0 to bit 0.
- R11: While a cycle runs, the following writes are ignored: pointer writes (addresses 2 and 3), holding-buffer writes, and writes to control bits 4, 6 and 7. The array port outputs stay stable.
- R12: Either reset clears the write-enable bit, the start bit, the mode bits, the pointer, the holding buffer and the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| rst_ni | input | 1 | Warm reset, active low, asynchronous; keeps the write-error bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address: 0 control, 1 key, 2 pointer low, 3 pointer high, 4 latch, 5 flags |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| mem_req_o | output | 1 | Programming cycle in progress |
| mem_erase_o | output | 1 | Cycle is an erase |
| mem_space_o | output | 2 | Target space: 00 data, 01 program, 10 configuration |
| mem_row_o | output | 13 | Row address, ptr[15:3] |
| mem_data_o | output | 64 | Holding buffer, entry i on bits 8*i+7:8*i |
| irq_o | output | 1 | Completion flag |

## Verification
The assertions check on every cycle that a cycle can begin only from an unlocked control write that has write-enable set. They also check that the write-error bit is high for as long as mem_req_o is, that the completion flag rises when a cycle ends and holds until a clearing write, that the key register reads zero, that the space code is legal, and that the array outputs do not move during a cycle. The bench scenarios cover the rest. These are the exact unlock orderings that fail, the length of the timer window, the ignored writes made during a cycle, and the write-error bit surviving a warm reset but not a power-on reset.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int unsigned BUS_W = 8;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_KEY   = 3'd1;
  localparam logic [2:0] A_PTRL  = 3'd2;
  localparam logic [2:0] A_PTRH  = 3'd3;
  localparam logic [2:0] A_LATCH = 3'd4;
  localparam logic [2:0] A_FLAGS = 3'd5;

  localparam int unsigned CB_START = 1;
  localparam int unsigned CB_WEN   = 2;
  localparam int unsigned CB_WERR  = 3;
  localparam int unsigned CB_ERASE = 4;
  localparam int unsigned CB_CFG   = 6;
  localparam int unsigned CB_MSEL  = 7;

  localparam logic [BUS_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BUS_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    SP_DATA = 2'b00,
    SP_PROG = 2'b01,
    SP_CFG  = 2'b10
  } space_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_pkg::*;
#(
  parameter logic [BUS_W-1:0] FIRST  = KEY_FIRST,
  parameter logic [BUS_W-1:0] SECOND = KEY_SECOND
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             key_we_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             armed_o
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (acc_i) begin
      if (key_we_i && wdata_i == FIRST)                        st_d = UL_HALF;
      else if (key_we_i && wdata_i == SECOND && st_q == UL_HALF) st_d = UL_ARMED;
      else                                                      st_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= UL_IDLE;
    else         st_q <= st_d;
  end

  assign armed_o = (st_q == UL_ARMED);
endmodule

// File: rtl/nvm_hold_buf.sv
module nvm_hold_buf #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [DEPTH*DW-1:0] flat_o
);
  logic [DW-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))           ent_q[g] <= wdata_i;
    end
    assign flat_o[g*DW +: DW] = ent_q[g];
  end

  assign rdata_o = ent_q[idx_i];
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int unsigned CYCLES = 20,
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LAST;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 20,
  parameter int unsigned HOLD_DEPTH  = 8,
  localparam int unsigned PTR_W = 2 * BUS_W,
  localparam int unsigned IDX_W = $clog2(HOLD_DEPTH),
  localparam int unsigned ROW_W = PTR_W - IDX_W
) (
  input  logic                        clk_i,
  input  logic                        por_ni,
  input  logic                        rst_ni,
  input  logic                        reg_we_i,
  input  logic                        reg_re_i,
  input  logic [2:0]                  reg_addr_i,
  input  logic [BUS_W-1:0]            reg_wdata_i,
  output logic [BUS_W-1:0]            reg_rdata_o,
  output logic                        mem_req_o,
  output logic                        mem_erase_o,
  output logic [1:0]                  mem_space_o,
  output logic [ROW_W-1:0]            mem_row_o,
  output logic [HOLD_DEPTH*BUS_W-1:0] mem_data_o,
  output logic                        irq_o
);
  logic rst_n_all;
  logic acc, wr_ctrl, wr_key, wr_ptrl, wr_ptrh, wr_latch, wr_flags;
  logic armed, busy, t_done, start_ok;
  logic wen_q, erase_q, cfg_q, msel_q, werr_q, done_q;
  logic [PTR_W-1:0] ptr_q;
  logic [BUS_W-1:0] hold_rd, ctrl_rd;
  space_e space;

  assign rst_n_all = rst_ni & por_ni;

  assign acc      = reg_we_i | reg_re_i;
  assign wr_ctrl  = reg_we_i && reg_addr_i == A_CTRL;
  assign wr_key   = reg_we_i && reg_addr_i == A_KEY;
  assign wr_ptrl  = reg_we_i && reg_addr_i == A_PTRL;
  assign wr_ptrh  = reg_we_i && reg_addr_i == A_PTRH;
  assign wr_latch = reg_we_i && reg_addr_i == A_LATCH;
  assign wr_flags = reg_we_i && reg_addr_i == A_FLAGS;

  nvm_unlock u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_all),
    .acc_i    (acc),
    .key_we_i (wr_key),
    .wdata_i  (reg_wdata_i),
    .armed_o  (armed)
  );

  // start needs unlock, write-enable in the same write, and an idle timer
  assign start_ok = wr_ctrl && reg_wdata_i[CB_START] && reg_wdata_i[CB_WEN] && armed && !busy;

  nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_all),
    .start_i (start_ok),
    .busy_o  (busy),
    .done_o  (t_done)
  );

  nvm_hold_buf #(.DEPTH(HOLD_DEPTH), .DW(BUS_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_all),
    .we_i    (wr_latch && !busy),
    .idx_i   (ptr_q[IDX_W-1:0]),
    .wdata_i (reg_wdata_i),
    .rdata_o (hold_rd),
    .flat_o  (mem_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_n_all) begin
    if (!rst_n_all) begin
      wen_q   <= 1'b0;
      erase_q <= 1'b0;
      cfg_q   <= 1'b0;
      msel_q  <= 1'b0;
    end else if (wr_ctrl) begin
      wen_q <= reg_wdata_i[CB_WEN];
      if (!busy) begin
        erase_q <= reg_wdata_i[CB_ERASE];
        cfg_q   <= reg_wdata_i[CB_CFG];
        msel_q  <= reg_wdata_i[CB_MSEL];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_all) begin
    if (!rst_n_all) begin
      ptr_q <= '0;
    end else if (!busy) begin
      if (wr_ptrl) ptr_q[BUS_W-1:0]     <= reg_wdata_i;
      if (wr_ptrh) ptr_q[PTR_W-1:BUS_W] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_all) begin
    if (!rst_n_all)                      done_q <= 1'b0;
    else if (t_done)                     done_q <= 1'b1;
    else if (wr_flags && !reg_wdata_i[0]) done_q <= 1'b0;
  end

  // write-error survives warm reset; only power-on clears it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)       werr_q <= 1'b0;
    else if (start_ok) werr_q <= 1'b1;
    else if (t_done)   werr_q <= 1'b0;
  end

  always_comb begin
    if (cfg_q)       space = SP_CFG;
    else if (msel_q) space = SP_PROG;
    else             space = SP_DATA;
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[CB_START] = busy;
    ctrl_rd[CB_WEN]   = wen_q;
    ctrl_rd[CB_WERR]  = werr_q;
    ctrl_rd[CB_ERASE] = erase_q;
    ctrl_rd[CB_CFG]   = cfg_q;
    ctrl_rd[CB_MSEL]  = msel_q;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_rd;
      A_PTRL:  reg_rdata_o = ptr_q[BUS_W-1:0];
      A_PTRH:  reg_rdata_o = ptr_q[PTR_W-1:BUS_W];
      A_LATCH: reg_rdata_o = hold_rd;
      A_FLAGS: reg_rdata_o = {{(BUS_W-1){1'b0}}, done_q};
      default: reg_rdata_o = '0;
    endcase
  end

  assign mem_req_o   = busy;
  assign mem_erase_o = erase_q;
  assign mem_space_o = space;
  assign mem_row_o   = ptr_q[PTR_W-1:IDX_W];
  assign irq_o       = done_q;
endmodule

// File: rtl/nvm_wr_ctrl_chk.sv
module nvm_wr_ctrl_chk
  import nvm_pkg::*;
#(
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              por_ni,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [2:0]        reg_addr_i,
  input logic [BUS_W-1:0]  reg_wdata_i,
  input logic [BUS_W-1:0]  reg_rdata_o,
  input logic              mem_req_o,
  input logic              mem_erase_o,
  input logic [1:0]        mem_space_o,
  input logic [ROW_W-1:0]  mem_row_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              irq_o,
  input logic              armed,
  input logic              werr_q
);
  AST_START_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(mem_req_o) |-> $past(armed)); // R3

  AST_START_NEEDS_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(mem_req_o) |-> $past(reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[CB_WEN])); // R4

  AST_WERR_DURING_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    mem_req_o |-> werr_q); // R6

  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $fell(mem_req_o) |-> irq_o); // R10

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    irq_o && !(reg_we_i && reg_addr_i == A_FLAGS && !reg_wdata_i[0]) |=> irq_o); // R10

  AST_KEY_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    reg_re_i && reg_addr_i == A_KEY |-> reg_rdata_o == '0); // R2

  AST_SPACE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    mem_space_o != 2'b11); // R8

  AST_PORT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    mem_req_o && $past(mem_req_o) |-> $stable(mem_row_o) && $stable(mem_data_o)
                                      && $stable(mem_erase_o) && $stable(mem_space_o)); // R11
endmodule

bind nvm_wr_ctrl nvm_wr_ctrl_chk #(.ROW_W(ROW_W), .DATA_W(HOLD_DEPTH*BUS_W)) u_chk (
  .clk_i       (clk_i),
  .por_ni      (por_ni),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mem_req_o   (mem_req_o),
  .mem_erase_o (mem_erase_o),
  .mem_space_o (mem_space_o),
  .mem_row_o   (mem_row_o),
  .mem_data_o  (mem_data_o),
  .irq_o       (irq_o),
  .armed       (armed),
  .werr_q      (werr_q)
);

// File: tb/nvm_wr_ctrl_test.sv
`timescale 1ns/1ps
module nvm_wr_ctrl_test;
  localparam int PROG = 20;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic req, erase, irq;
  logic [1:0] space;
  logic [12:0] row;
  logic [63:0] data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nvm_wr_ctrl #(.PROG_CYCLES(PROG), .HOLD_DEPTH(8)) uut (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mem_req_o(req), .mem_erase_o(erase),
    .mem_space_o(space), .mem_row_o(row), .mem_data_o(data), .irq_o(irq)
  );

  // behavioural reference
  bit m_wen, m_erase, m_cfg, m_msel, m_werr, m_done, m_busy;
  int m_cnt, m_ulk, m_ptr;
  int m_hold [8];

  always @(posedge clk) begin
    if (!por_n || !rst_n) begin
      if (!por_n) m_werr = 0;
      m_wen = 0; m_erase = 0; m_cfg = 0; m_msel = 0; m_done = 0;
      m_busy = 0; m_cnt = 0; m_ulk = 0; m_ptr = 0;
      foreach (m_hold[i]) m_hold[i] = 0;
    end else begin
      automatic bit ob = m_busy;
      automatic int ocnt = m_cnt;
      automatic int oul = m_ulk;
      if (we || re) begin
        if (we && addr == 1 && wdata == 8'h55) m_ulk = 1;
        else if (we && addr == 1 && wdata == 8'hAA && oul == 1) m_ulk = 2;
        else m_ulk = 0;
      end
      if (we) begin
        case (addr)
          3'd0: begin
            m_wen = wdata[2];
            if (!ob) begin
              m_erase = wdata[4]; m_cfg = wdata[6]; m_msel = wdata[7];
              if (wdata[1] && wdata[2] && oul == 2) begin
                m_busy = 1; m_werr = 1; m_cnt = PROG - 1;
              end
            end
          end
          3'd2: if (!ob) m_ptr = (m_ptr & 32'hFF00) | wdata;
          3'd3: if (!ob) m_ptr = (m_ptr & 32'h00FF) | (int'(wdata) << 8);
          3'd4: if (!ob) m_hold[m_ptr % 8] = wdata;
          3'd5: if (!wdata[0]) m_done = 0;
          default: ;
        endcase
      end
      if (ob) begin
        if (ocnt == 0) begin m_busy = 0; m_werr = 0; m_done = 1; end
        else m_cnt = ocnt - 1;
      end
    end
  end

  function automatic logic [7:0] m_read(input int a);
    case (a)
      0: return {m_msel, m_cfg, 1'b0, m_erase, m_werr, m_wen, m_busy, 1'b0};
      2: return m_ptr[7:0];
      3: return m_ptr[15:8];
      4: return m_hold[m_ptr % 8][7:0];
      5: return {7'b0, m_done};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [63:0] m_data();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_hold[i][7:0];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison of the array port and interrupt
  always @(negedge clk) begin
    if (por_n && rst_n && !finished) begin
      chk("R9 mem_req_o", req, m_busy);
      chk("R7 mem_erase_o", erase, m_erase);
      chk("R8 mem_space_o", space, m_cfg ? 2'b10 : (m_msel ? 2'b01 : 2'b00));
      chk("R9 mem_row_o", row, m_ptr[15:3]);
      chk("R1 mem_data_o", data, m_data());
      chk("R10 irq_o", irq, m_done);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, output logic [7:0] v);
    @(negedge clk); re = 1'b1; addr = a;
    #2 v = rdata;
    chk(tag, v, m_read(a));
    @(negedge clk); re = 1'b0;
  endtask

  task automatic unlock();
    wr(3'd1, 8'h55);
    wr(3'd1, 8'hAA);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    #1 por_n = 1'b1; rst_n = 1'b1;

    rd(3'd0, "R12 ctrl after reset", v);
    chk("R12 ctrl zero", v, 8'h00);
    rd(3'd5, "R12 flags after reset", v);
    chk("R12 done zero", v, 8'h00);

    // holding buffer
    wr(3'd2, 8'h35); wr(3'd3, 8'h12);
    wr(3'd4, 8'hC3);
    rd(3'd4, "R1 latch read", v);
    chk("R1 entry5", v, 8'hC3);
    wr(3'd2, 8'h30); wr(3'd4, 8'h11);
    wr(3'd2, 8'h37); wr(3'd4, 8'h77);
    chk("R1 bits 47:40", data[40 +: 8], 8'hC3);
    chk("R1 bits 7:0", data[0 +: 8], 8'h11);
    chk("R1 bits 63:56", data[56 +: 8], 8'h77);
    chk("R9 row", row, 13'h0246);

    // key register
    wr(3'd1, 8'h55);
    rd(3'd1, "R2 key read", v);
    chk("R2 key zero", v, 8'h00);

    // data space select, no start
    wr(3'd0, 8'h04);
    chk("R8 data space", space, 2'b00);

    // no unlock
    wr(3'd0, 8'h86);
    chk("R3 no key", req, 1'b0);
    rd(3'd0, "R3 ctrl", v);
    chk("R3 start clear", v[1], 1'b0);

    // unlock but write-enable clear
    unlock(); wr(3'd0, 8'h82);
    chk("R4 no wen", req, 1'b0);
    rd(3'd0, "R4 ctrl", v);
    chk("R4 ctrl value", v, 8'h80);

    // intervening read
    wr(3'd1, 8'h55); rd(3'd2, "R3 intervening", v); wr(3'd1, 8'hAA);
    wr(3'd0, 8'h86);
    chk("R3 intervening access", req, 1'b0);

    // wrong order
    wr(3'd1, 8'hAA); wr(3'd1, 8'h55); wr(3'd0, 8'h86);
    chk("R3 wrong order", req, 1'b0);

    // proper program write
    unlock(); wr(3'd0, 8'h86);
    chk("R3 started", req, 1'b1);
    chk("R8 program space", space, 2'b01);
    chk("R7 write not erase", erase, 1'b0);
    rd(3'd0, "R6 ctrl busy", v);
    chk("R5/R6 start and werr", v, 8'h8E);
    wr(3'd0, 8'h44);
    rd(3'd0, "R5 ctrl", v);
    chk("R5 start held", v[1], 1'b1);
    chk("R11 mode frozen", space, 2'b01);
    wr(3'd2, 8'h00);
    chk("R11 ptr frozen", row, 13'h0246);
    wr(3'd4, 8'hEE);
    chk("R11 latch frozen", data[56 +: 8], 8'h77);
    n = 0;
    while (req && n < 1000) begin n++; @(negedge clk); end
    rd(3'd0, "R5 ctrl after", v);
    chk("R5/R6 start and werr cleared", v, 8'h84);
    chk("R10 irq set", irq, 1'b1);
    repeat (5) @(negedge clk);
    chk("R10 irq sticky", irq, 1'b1);
    wr(3'd5, 8'h01);
    chk("R10 write one ignored", irq, 1'b1);
    wr(3'd5, 8'h00);
    chk("R10 cleared", irq, 1'b0);

    // configuration erase, timer length
    unlock(); wr(3'd0, 8'h56);
    chk("R7 erase", erase, 1'b1);
    chk("R8 cfg space", space, 2'b10);
    n = 0;
    while (req && n < 1000) begin n++; @(negedge clk); end
    chk("R9 cycle length", n, PROG);

    // cfg overrides select, warm reset mid-cycle
    unlock(); wr(3'd0, 8'hC6);
    chk("R8 cfg overrides", space, 2'b10);
    chk("R7 write", erase, 1'b0);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    chk("R6 req off", req, 1'b0);
    rd(3'd0, "R6 ctrl after warm reset", v);
    chk("R6/R12 werr kept", v, 8'h08);
    chk("R12 row cleared", row, 13'h0);

    @(negedge clk); #1 por_n = 1'b0;
    @(negedge clk); #1 por_n = 1'b1;
    rd(3'd0, "R6 ctrl after por", v);
    chk("R6 werr cleared by por", v, 8'h00);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule